// File: doc/BRIEF.md
# Interval Timer with Register Interface

This block is a 32-bit down-counting interval timer that sits on a plain word-addressed register bus and drives one level-sensitive interrupt line. Software programs the interval as two 16-bit halves, sets the interrupt enable and the reload mode in a control word, and starts or stops the count with command bits that are not stored. When the count runs out, a sticky timeout flag is raised and the period is loaded again. In continuous mode the timer keeps going. In one-shot mode it stops and waits at the period value.

The live count is never read directly. A write to either snapshot word latches the full count, and software then reads the two halves at leisure. Reads are combinational, so the data for the addressed word is valid in the cycle of the access. Writes take effect at the next rising clock edge. The word index is the byte address with its two low bits dropped.

Top module: `interval_timer`

## Requirements
- R1: After reset every register word reads zero, `irq` is low, the timer is stopped and the counter holds all ones; a snapshot taken straight after reset reads 0xFFFF in both halves.
- R2: Word indexes are status=0, control=1, period low=2, period high=3, snapshot low=4, snapshot high=5, taken from address bits [ADDR_W-1:2]. Status bit 0 is the timeout flag and bit 1 is the running flag. Control bit 0 is the interrupt enable and bit 1 is continuous mode, and a control read returns only those two bits. Unused bits read zero. Indexes 6 and above read zero, and writes to them change nothing.
- R3: Control bit 2 (start) sets the running flag only if the timer is stopped. Control bit 3 (stop) clears it only if the timer is running. With both bits set in one write, the timer ends up stopped.
- R4: On every clock edge at which the running flag is already set, the counter either decrements by one or reloads. A write to word 4 or 5 latches the pre-edge count: the low 16 bits go to word 4 and the high 16 bits to word 5.
- R5: A write to word 2 or 3 stores only the low 16 bits of the data, loads the counter with the resulting 32-bit period, and stops the timer if it is running.
- R6: The interval is period+1 counting cycles. Expiry is the running edge at which the count is zero, and the timeout flag reads one from the following cycle.
- R7: In one-shot mode (control bit 1 clear), expiry clears the running flag and leaves the counter at the period value.
- R8: In continuous mode, expiry reloads the period and the timer keeps running.
- R9: Any write to word 0 clears the timeout flag, whatever the data. If an expiry falls on the same edge, the flag stays set.
- R10: `irq` is high exactly when the timeout flag and the interrupt enable are both set. It changes on the same edge as those bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, same cycle |
| irq | output | 1 | Level interrupt: timeout and enable both set |

## Verification
The assertions assume one access per cycle to a single word index. They also assume that the period and control fields use only the bit positions given above, and that no write arrives while `rst` is high. The bench stays within these limits. It changes bus inputs only on the falling edge, issues exactly one operation per cycle, and masks random period data to a few low bits so that expiries, reloads and flag collisions happen often inside the run. It also lines up status writes with expiry edges on purpose, using a zero period in continuous mode, to exercise the rule that a set and a clear on the same edge leave the flag set.

// File: rtl/timer_pkg.sv
package timer_pkg;

  // Word indexes; software depends on this placement.
  localparam int IDX_STATUS  = 0;
  localparam int IDX_CTRL    = 1;
  localparam int IDX_PER_LO  = 2;
  localparam int IDX_PER_HI  = 3;
  localparam int IDX_SNAP_LO = 4;
  localparam int IDX_SNAP_HI = 5;
  localparam int NUM_REGS    = 6;

  // Status bit positions
  localparam int ST_TO  = 0;
  localparam int ST_RUN = 1;

  // Control bit positions
  localparam int CT_IEN   = 0;
  localparam int CT_CONT  = 1;
  localparam int CT_START = 2;
  localparam int CT_STOP  = 3;
  localparam int CT_W     = 4;

  typedef struct packed {
    logic status_wr;
    logic ctrl_wr;
    logic per_lo_wr;
    logic per_hi_wr;
    logic snap_wr;
  } reg_wr_t;

endpackage

// File: rtl/timer_decode.sv
module timer_decode
  import timer_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             wr_en,
  input  logic [IDX_W-1:0] word_idx,
  output reg_wr_t          wr_s
);

  logic [NUM_REGS-1:0] hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign hit[i] = wr_en && (word_idx == IDX_W'(i));
  end

  assign wr_s.status_wr = hit[IDX_STATUS];
  assign wr_s.ctrl_wr   = hit[IDX_CTRL];
  assign wr_s.per_lo_wr = hit[IDX_PER_LO];
  assign wr_s.per_hi_wr = hit[IDX_PER_HI];
  assign wr_s.snap_wr   = hit[IDX_SNAP_LO] | hit[IDX_SNAP_HI];

endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              per_lo_wr,
  input  logic              per_hi_wr,
  input  logic [CNT_W/2-1:0] wr_half,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  period,
  output logic              expire
);

  localparam int HALF_W = CNT_W / 2;

  logic [HALF_W-1:0] per_lo_q, per_hi_q;
  logic [HALF_W-1:0] per_lo_d, per_hi_d;

  assign per_lo_d = per_lo_wr ? wr_half : per_lo_q;
  assign per_hi_d = per_hi_wr ? wr_half : per_hi_q;
  assign period   = {per_hi_q, per_lo_q};
  assign expire   = run && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_lo_q <= '0;
      per_hi_q <= '0;
      count    <= '1;
    end else begin
      per_lo_q <= per_lo_d;
      per_hi_q <= per_hi_d;
      if (per_lo_wr || per_hi_wr)
        count <= {per_hi_d, per_lo_d};
      else if (expire)
        count <= period;
      else if (run)
        count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/timer_flags.sv
module timer_flags
  import timer_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ctrl_wr,
  input  logic [CT_W-1:0] ctrl_bits,
  input  logic            status_wr,
  input  logic            per_wr,
  input  logic            expire,
  output logic            run_q,
  output logic            to_q,
  output logic            ien_q,
  output logic            cont_q,
  output logic            irq_q
);

  logic start_eff, stop_eff;
  logic run_d, to_d, ien_d, cont_d;

  assign start_eff = ctrl_wr && ctrl_bits[CT_START] && !run_q;
  assign stop_eff  = ctrl_wr && ctrl_bits[CT_STOP] && (run_q || start_eff);

  always_comb begin
    if (per_wr || stop_eff)    run_d = 1'b0;
    else if (start_eff)        run_d = 1'b1;
    else if (expire && !cont_q) run_d = 1'b0;
    else                       run_d = run_q;
  end

  assign to_d   = expire ? 1'b1 : (status_wr ? 1'b0 : to_q);
  assign ien_d  = ctrl_wr ? ctrl_bits[CT_IEN]  : ien_q;
  assign cont_d = ctrl_wr ? ctrl_bits[CT_CONT] : cont_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      to_q   <= 1'b0;
      ien_q  <= 1'b0;
      cont_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      to_q   <= to_d;
      ien_q  <= ien_d;
      cont_q <= cont_d;
      irq_q  <= to_d & ien_d;
    end
  end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam int HALF_W = CNT_W / 2;
  localparam int IDX_W  = ADDR_W - 2;
  localparam logic [IDX_W-1:0] W_STATUS  = IDX_W'(IDX_STATUS);
  localparam logic [IDX_W-1:0] W_CTRL    = IDX_W'(IDX_CTRL);
  localparam logic [IDX_W-1:0] W_PER_LO  = IDX_W'(IDX_PER_LO);
  localparam logic [IDX_W-1:0] W_PER_HI  = IDX_W'(IDX_PER_HI);
  localparam logic [IDX_W-1:0] W_SNAP_LO = IDX_W'(IDX_SNAP_LO);
  localparam logic [IDX_W-1:0] W_SNAP_HI = IDX_W'(IDX_SNAP_HI);

  logic [IDX_W-1:0]  word_idx;
  reg_wr_t           wr_s;
  logic [CNT_W-1:0]  count, period;
  logic              expire;
  logic              run_flag, to_flag, ien_flag, cont_flag;
  logic [HALF_W-1:0] snap_lo, snap_hi;

  assign word_idx = addr[ADDR_W-1:2];

  timer_decode #(.IDX_W(IDX_W)) u_dec (
    .wr_en    (wr_en),
    .word_idx (word_idx),
    .wr_s     (wr_s)
  );

  timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .run       (run_flag),
    .per_lo_wr (wr_s.per_lo_wr),
    .per_hi_wr (wr_s.per_hi_wr),
    .wr_half   (wdata[HALF_W-1:0]),
    .count     (count),
    .period    (period),
    .expire    (expire)
  );

  timer_flags u_flg (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (wr_s.ctrl_wr),
    .ctrl_bits (wdata[CT_W-1:0]),
    .status_wr (wr_s.status_wr),
    .per_wr    (wr_s.per_lo_wr | wr_s.per_hi_wr),
    .expire    (expire),
    .run_q     (run_flag),
    .to_q      (to_flag),
    .ien_q     (ien_flag),
    .cont_q    (cont_flag),
    .irq_q     (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_lo <= '0;
      snap_hi <= '0;
    end else if (wr_s.snap_wr) begin
      snap_lo <= count[HALF_W-1:0];
      snap_hi <= count[CNT_W-1:HALF_W];
    end
  end

  always_comb begin
    rdata = '0;
    case (word_idx)
      W_STATUS: begin
        rdata[ST_TO]  = to_flag;
        rdata[ST_RUN] = run_flag;
      end
      W_CTRL: begin
        rdata[CT_IEN]  = ien_flag;
        rdata[CT_CONT] = cont_flag;
      end
      W_PER_LO:  rdata[HALF_W-1:0] = period[HALF_W-1:0];
      W_PER_HI:  rdata[HALF_W-1:0] = period[CNT_W-1:HALF_W];
      W_SNAP_LO: rdata[HALF_W-1:0] = snap_lo;
      W_SNAP_HI: rdata[HALF_W-1:0] = snap_hi;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/timer_chk.sv
module timer_chk
  import timer_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [IDX_W-1:0]  word_idx,
  input logic [DATA_W-1:0] wdata,
  input logic              run_flag,
  input logic              to_flag,
  input logic              ien_flag,
  input logic              cont_flag,
  input logic              irq,
  input logic              expire,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  period
);

  localparam int HALF_W = CNT_W / 2;

  logic wr_status, wr_ctrl, wr_plo, wr_per;
  assign wr_status = wr_en && (word_idx == IDX_W'(IDX_STATUS));
  assign wr_ctrl   = wr_en && (word_idx == IDX_W'(IDX_CTRL));
  assign wr_plo    = wr_en && (word_idx == IDX_W'(IDX_PER_LO));
  assign wr_per    = wr_plo || (wr_en && (word_idx == IDX_W'(IDX_PER_HI)));

  p_irq_match_r10: assert property (@(posedge clk) disable iff (rst)
    irq == (to_flag && ien_flag));

  p_start_r3: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl && wdata[CT_START] && !wdata[CT_STOP] && !run_flag |=> run_flag);

  p_stop_r3: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl && wdata[CT_STOP] |=> !run_flag);

  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    run_flag && !expire && !wr_per |=> count == $past(count) - 1'b1);

  p_per_stop_r5: assert property (@(posedge clk) disable iff (rst)
    wr_per |=> !run_flag);

  p_per_load_r5: assert property (@(posedge clk) disable iff (rst)
    wr_plo |=> count[HALF_W-1:0] == $past(wdata[HALF_W-1:0]));

  p_to_set_r6: assert property (@(posedge clk) disable iff (rst)
    expire |=> to_flag);

  p_oneshot_r7: assert property (@(posedge clk) disable iff (rst)
    expire && !cont_flag |=> !run_flag);

  p_reload_r8: assert property (@(posedge clk) disable iff (rst)
    expire && !wr_per |=> count == $past(period));

  p_to_clear_r9: assert property (@(posedge clk) disable iff (rst)
    wr_status && !expire |=> !to_flag);

endmodule

bind interval_timer timer_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .word_idx  (word_idx),
  .wdata     (wdata),
  .run_flag  (run_flag),
  .to_flag   (to_flag),
  .ien_flag  (ien_flag),
  .cont_flag (cont_flag),
  .irq       (irq),
  .expire    (expire),
  .count     (count),
  .period    (period)
);

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  wire  [DATA_W-1:0] rdata;
  wire               irq;

  always #2.5 clk = ~clk;

  interval_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // Behavioural reference state
  bit [31:0] m_cnt = 32'hFFFF_FFFF;
  bit [15:0] m_plo = 0, m_phi = 0, m_slo = 0, m_shi = 0;
  bit        m_run = 0, m_to = 0, m_ien = 0, m_cont = 0, m_irq = 0;

  function automatic bit [31:0] m_read(int idx);
    case (idx)
      0: return {30'd0, m_run, m_to};
      1: return {30'd0, m_cont, m_ien};
      2: return {16'd0, m_plo};
      3: return {16'd0, m_phi};
      4: return {16'd0, m_slo};
      5: return {16'd0, m_shi};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string what, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_update(bit wr, int idx, bit [31:0] d);
    bit        ex;
    bit [31:0] ncnt;
    bit        nrun, nto;
    ex   = m_run && (m_cnt == 0);
    ncnt = m_cnt;
    nrun = m_run;
    nto  = m_to;
    if (m_run) begin
      if (ex) begin
        ncnt = {m_phi, m_plo};
        nto  = 1;
        if (!m_cont) nrun = 0;
      end else begin
        ncnt = m_cnt - 1;
      end
    end
    if (wr) begin
      case (idx)
        0: if (!ex) nto = 0;
        1: begin
          if (d[2] && !m_run) nrun = 1;
          if (d[3] && (m_run || d[2])) nrun = 0;
          m_ien  = d[0];
          m_cont = d[1];
        end
        2: begin m_plo = d[15:0]; ncnt = {m_phi, m_plo}; nrun = 0; end
        3: begin m_phi = d[15:0]; ncnt = {m_phi, m_plo}; nrun = 0; end
        4, 5: begin m_slo = m_cnt[15:0]; m_shi = m_cnt[31:16]; end
        default: ;
      endcase
    end
    m_cnt = ncnt;
    m_run = nrun;
    m_to  = nto;
    m_irq = nto & m_ien;
  endtask

  // One bus cycle: drive, check the read path, clock, check irq.
  task automatic step(bit wr, int idx, bit [31:0] d);
    @(negedge clk);
    wr_en = wr;
    addr  = ADDR_W'(idx * 4 + (idx % 3));
    wdata = d;
    #1;
    check($sformatf("rdata[%0d]", idx), rdata, m_read(idx));
    @(posedge clk);
    model_update(wr, idx, d);
    #1;
    check("irq", {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic idle(int n, int idx);
    for (int i = 0; i < n; i++) step(0, idx, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state, including an all-ones counter seen via snapshot
    cur_req = "R1";
    for (int k = 0; k < 8; k++) step(0, k, 0);
    step(1, 4, 32'h1234_5678);
    step(0, 4, 0);
    step(0, 5, 0);

    // R2: control read masking, unmapped indexes
    cur_req = "R2";
    step(1, 1, 32'hFFFF_FFF3);
    step(0, 1, 0);
    step(1, 1, 32'h0000_00F0);
    step(0, 1, 0);
    step(1, 6, 32'hFFFF_FFFF);
    step(1, 63, 32'hFFFF_FFFF);
    step(0, 6, 0);
    step(0, 63, 0);
    idle(2, 0);

    // R5: only low 16 bits stored, counter loaded
    cur_req = "R5";
    step(1, 2, 32'hABCD_0003);
    step(1, 3, 32'h5555_0000);
    step(0, 2, 0);
    step(0, 3, 0);
    step(1, 4, 0);
    step(0, 4, 0);

    // R6 and R7: one-shot with interrupt enabled
    cur_req = "R6";
    step(1, 1, 32'h5);
    idle(8, 0);
    cur_req = "R7";
    step(1, 4, 0);
    step(0, 4, 0);
    step(0, 5, 0);

    // R9: any data clears timeout
    cur_req = "R9";
    step(1, 0, 32'hFFFF_FFFF);
    step(0, 0, 0);

    // R8: continuous reload with interrupt
    cur_req = "R8";
    step(1, 2, 32'h2);
    step(1, 1, 32'h7);
    for (int i = 0; i < 14; i++) step(i % 4 == 3, 0, 0);

    // R3: start/stop rules
    cur_req = "R3";
    step(1, 1, 32'h6);
    step(0, 0, 0);
    step(1, 1, 32'hA);
    step(0, 0, 0);
    step(1, 1, 32'h8);
    step(1, 1, 32'hC);
    step(0, 0, 0);
    step(1, 1, 32'h6);
    step(0, 0, 0);
    step(1, 1, 32'hE);
    step(0, 0, 0);

    // R4: live snapshots while counting a long period
    cur_req = "R4";
    step(1, 3, 32'h0001);
    step(1, 1, 32'h4);
    for (int i = 0; i < 10; i++) begin
      step(1, 4 + (i % 2), 0);
      step(0, 4, 0);
      step(0, 5, 0);
    end

    // R5: period write while running stops it
    cur_req = "R5";
    step(1, 2, 32'h0010);
    step(0, 0, 0);
    step(1, 4, 0);
    step(0, 4, 0);
    step(0, 5, 0);

    // R9: zero period, continuous: expiry every edge beats status writes
    cur_req = "R9";
    step(1, 3, 0);
    step(1, 2, 0);
    step(1, 1, 32'h7);
    for (int i = 0; i < 6; i++) step(1, 0, 0);
    step(1, 1, 32'h8);
    step(1, 0, 0);
    step(0, 0, 0);

    // R10: interrupt follows enable and flag
    cur_req = "R10";
    step(1, 2, 32'h1);
    step(1, 1, 32'h4);
    idle(4, 0);
    step(1, 1, 32'h1);
    step(1, 1, 32'h0);
    step(1, 1, 32'h1);
    step(1, 0, 0);
    step(0, 0, 0);

    // Mixed traffic
    cur_req = "R4";
    for (int i = 0; i < 3000; i++) begin
      int        idx;
      bit [31:0] d;
      bit        wr;
      idx = int'($urandom_range(0, 7));
      d   = $urandom;
      wr  = ($urandom_range(0, 2) == 0);
      if (idx == 3) d = d & 32'h0;
      if (idx == 2) d = d & 32'h7;
      if (idx == 1 && d[3] && ($urandom_range(0, 3) != 0)) d[3] = 1'b0;
      step(wr, idx, d);
    end

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R1-related run): actual timeout expected completion");
      finish_run();
    end
  end

endmodule